// File: doc/BRIEF.md
# Masked Read-Modify-Write Engine

This block updates one element of a small synchronous word memory in a single indivisible operation. The element can be a byte, a 16-bit half or a 32-bit word. The requester supplies a byte address, a size code, new data and a bit mask of the element's width. The engine reads the stored element and merges the new data into it bit by bit under the mask. It then writes the result back and returns the value the element held before the update. Typical uses are semaphores, flag words and pixel fields narrower than the storage element.

The same path also serves plain accesses. An all-zero mask makes the operation a read with no write cycle. An all-ones mask makes it a write that also returns the old contents. The memory inside the block is an array of 32-bit words with per-byte write enables and a read latency set by a parameter. While an operation is in flight no other access can reach the memory, so nothing can come between the read and the write.

Top module: `masked_rmw_engine`

## Requirements
- R1: After reset, done_o, busy_o, err_o and old_o are all zero, and every memory word reads back as zero.
- R2: size_i encodes the element width: 0 is a byte, 1 is a 16-bit half, 2 is a 32-bit word. The word index is addr_i[ADDR_W-1:2]. Lanes are little-endian: a byte sits at lane addr_i[1:0] and a half at lanes 2*addr_i[1] and 2*addr_i[1]+1. old_o returns the element in its low bits with the upper bits zero.
- R3: The stored element becomes (old AND NOT m) OR (d AND m), where m and d are mask_i and data_i cut to the element width. Bits of mask_i and data_i above the element width have no effect.
- R4: old_o, valid in the done cycle, holds the element value from before the operation's own update.
- R5: When the mask cut to the element width is zero, no write happens, memory is unchanged, and done_o rises RD_LAT+1 cycles after the edge that accepted start_i.
- R6: When the cut mask is nonzero, only the byte lanes of the element are written, other bytes of the word keep their value, and done_o rises RD_LAT+2 cycles after the accepting edge.
- R7: done_o is a one-cycle pulse. busy_o is high from the cycle after acceptance up to, but not including, the done cycle.
- R8: A half at an odd address, a word at an address that is not a multiple of four, or size code 3 gives done_o with err_o high one cycle after acceptance. In that case old_o is zero and memory is untouched.
- R9: start_i is ignored while busy_o is high. Each operation issues exactly one memory read, and no other access comes between that read and its write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when busy_o is low |
| addr_i | input | ADDR_W | Byte address of the element |
| size_i | input | 2 | Element size code (0 byte, 1 half, 2 word) |
| data_i | input | 32 | New element bits, right-aligned |
| mask_i | input | 32 | Bit-select mask, right-aligned, ones replace |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Alignment or size fault, valid with done_o |
| old_o | output | 32 | Element value before the update, valid with done_o |

## Verification
The bench targets narrow updates inside a word that already holds data. A design with wrong lane placement or wrong byte enables would corrupt neighbouring bytes, and the final sweep of the whole memory exposes that. It sets garbage bits above the element width in data and mask: a design that fails to cut them would write extra lanes, or would take a write path when the cut mask is zero. That second fault shows up as a latency one cycle too long. Misaligned and reserved-size requests must finish in a single cycle with no memory change. A start pulse sent in the middle of an operation must neither start a second operation nor produce an extra done pulse.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } eng_state_e;

    // Bits covered by an element of the given size, right-aligned.
    function automatic logic [WORD_W-1:0] width_mask(input elem_size_e sz);
        case (sz)
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_HALF: width_mask = 32'h0000_FFFF;
            SZ_WORD: width_mask = 32'hFFFF_FFFF;
            default: width_mask = '0;
        endcase
    endfunction

    function automatic logic [2:0] byte_count(input elem_size_e sz);
        case (sz)
            SZ_BYTE: byte_count = 3'd1;
            SZ_HALF: byte_count = 3'd2;
            SZ_WORD: byte_count = 3'd4;
            default: byte_count = 3'd0;
        endcase
    endfunction

    // Ones in sel take the bit from fresh, zeros keep the bit from prior.
    function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] prior,
                                                     input logic [WORD_W-1:0] fresh,
                                                     input logic [WORD_W-1:0] sel);
        merge_bits = (prior & ~sel) | (fresh & sel);
    endfunction

endpackage

// File: rtl/rmw_lane_map.sv
// Places a right-aligned element into its byte lanes and flags bad alignment.
module rmw_lane_map
    import rmw_pkg::*;
(
    input  elem_size_e          size_i,
    input  logic [1:0]          offs_i,
    input  logic [WORD_W-1:0]   data_i,
    input  logic [WORD_W-1:0]   mask_i,
    output logic [WORD_W-1:0]   data_w_o,
    output logic [WORD_W-1:0]   mask_w_o,
    output logic [LANES-1:0]    be_o,
    output logic                bad_o
);

    logic [WORD_W-1:0] wmask;
    logic [2:0]        nbytes;
    logic [4:0]        shamt;
    logic [2:0]        lane_lo;
    logic [2:0]        lane_hi;

    always_comb begin
        wmask  = width_mask(size_i);
        nbytes = byte_count(size_i);
        shamt  = {offs_i, 3'b000};
        case (size_i)
            SZ_BYTE: bad_o = 1'b0;
            SZ_HALF: bad_o = offs_i[0];
            SZ_WORD: bad_o = |offs_i;
            default: bad_o = 1'b1;
        endcase
        data_w_o = (data_i & wmask) << shamt;
        mask_w_o = (mask_i & wmask) << shamt;
        lane_lo  = {1'b0, offs_i};
        lane_hi  = lane_lo + nbytes;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [2:0] LANE = 3'(l);
        assign be_o[l] = ~bad_o & (LANE >= lane_lo) & (LANE < lane_hi);
    end

endmodule

// File: rtl/rmw_lane_extract.sv
// Pulls an element out of a memory word and right-aligns it.
module rmw_lane_extract
    import rmw_pkg::*;
(
    input  elem_size_e          size_i,
    input  logic [1:0]          offs_i,
    input  logic [WORD_W-1:0]   word_i,
    output logic [WORD_W-1:0]   elem_o
);

    logic [4:0] shamt;

    always_comb begin
        shamt  = {offs_i, 3'b000};
        elem_o = (word_i >> shamt) & width_mask(size_i);
    end

endmodule

// File: rtl/rmw_word_mem.sv
// Word array with byte-lane write enables and a fixed read pipeline.
module rmw_word_mem
    import rmw_pkg::*;
#(
    parameter int WA     = 6,
    parameter int RD_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en_i,
    input  logic [WA-1:0]       rd_addr_i,
    input  logic                we_i,
    input  logic [WA-1:0]       wr_addr_i,
    input  logic [LANES-1:0]    be_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    output logic                rvalid_o
);

    localparam int DEPTH = 1 << WA;

    logic [WORD_W-1:0] mem_q  [DEPTH];
    logic [WORD_W-1:0] pipe_q [RD_LAT];
    logic [RD_LAT-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else if (we_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (be_i[l]) begin
                    mem_q[wr_addr_i][8*l +: 8] <= wdata_i[8*l +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= '0;
            vld_q[0]  <= 1'b0;
        end else begin
            vld_q[0] <= rd_en_i;
            if (rd_en_i) begin
                pipe_q[0] <= mem_q[rd_addr_i];
            end
        end
    end

    for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[s] <= '0;
                vld_q[s]  <= 1'b0;
            end else begin
                pipe_q[s] <= pipe_q[s-1];
                vld_q[s]  <= vld_q[s-1];
            end
        end
    end

    assign rdata_o  = pipe_q[RD_LAT-1];
    assign rvalid_o = vld_q[RD_LAT-1];

endmodule

// File: rtl/masked_rmw_engine.sv
module masked_rmw_engine
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int RD_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          size_i,
    input  logic [31:0]         data_i,
    input  logic [31:0]         mask_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [31:0]         old_o
);

    localparam int WA = ADDR_W - 2;

    typedef struct packed {
        eng_state_e         st;
        logic [ADDR_W-1:0]  addr;
        elem_size_e         size;
        logic [WORD_W-1:0]  data;
        logic [WORD_W-1:0]  mask;
        logic [WORD_W-1:0]  old_word;
        logic [WORD_W-1:0]  old_elem;
        logic               done;
        logic               err;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic [WORD_W-1:0] data_w, mask_w, wdata, rdata, rd_elem;
    logic [LANES-1:0]  be;
    logic              bad;
    logic              mem_rd_en, mem_we, mem_rvalid;

    rmw_lane_map u_map (
        .size_i   (r_q.size),
        .offs_i   (r_q.addr[1:0]),
        .data_i   (r_q.data),
        .mask_i   (r_q.mask),
        .data_w_o (data_w),
        .mask_w_o (mask_w),
        .be_o     (be),
        .bad_o    (bad)
    );

    rmw_lane_extract u_extract (
        .size_i (r_q.size),
        .offs_i (r_q.addr[1:0]),
        .word_i (rdata),
        .elem_o (rd_elem)
    );

    rmw_word_mem #(
        .WA     (WA),
        .RD_LAT (RD_LAT)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (mem_rd_en),
        .rd_addr_i (r_q.addr[ADDR_W-1:2]),
        .we_i      (mem_we),
        .wr_addr_i (r_q.addr[ADDR_W-1:2]),
        .be_i      (be),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .rvalid_o  (mem_rvalid)
    );

    assign mem_rd_en = (r_q.st == ST_ISSUE) && !bad;
    assign mem_we    = (r_q.st == ST_WRITE);
    assign wdata     = merge_bits(r_q.old_word, data_w, mask_w);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr = addr_i;
                    r_d.size = elem_size_e'(size_i);
                    r_d.data = data_i;
                    r_d.mask = mask_i;
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (bad) begin
                    r_d.done     = 1'b1;
                    r_d.err      = 1'b1;
                    r_d.old_elem = '0;
                    r_d.st       = ST_IDLE;
                end else begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    r_d.old_word = rdata;
                    r_d.old_elem = rd_elem;
                    if (mask_w == '0) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign old_o  = r_q.old_elem;

endmodule

// File: rtl/rmw_checker.sv
module rmw_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic mem_rd_en,
    input logic mem_we,
    input logic mem_rvalid
);

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: engine is free in the completion cycle
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: a write-back is followed by a clean completion
    a_r6_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (done_o && !err_o));

    // R9: read and write never share a cycle
    a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !mem_we);

    // R9: no new read is issued while read data returns
    a_r9_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> !mem_rd_en);

    // R8: a faulted request made no memory access in its only cycle
    a_r8_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> $past(!mem_we && !mem_rd_en));

endmodule

bind masked_rmw_engine rmw_checker u_rmw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .mem_rd_en  (mem_rd_en),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid)
);

// File: tb/masked_rmw_engine_tb_top.sv
`timescale 1ns/1ps
module masked_rmw_engine_tb_top;

    localparam int AW  = 8;
    localparam int RL  = 2;
    localparam int NB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [AW-1:0] addr_i;
    logic [1:0]    size_i;
    logic [31:0]   data_i, mask_i;
    logic          busy_o, done_o, err_o;
    logic [31:0]   old_o;

    logic [7:0] ref_mem [NB];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    masked_rmw_engine #(.ADDR_W(AW), .RD_LAT(RL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .size_i(size_i), .data_i(data_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .old_o(old_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One operation, compared against the byte model on every cycle.
    task automatic run_op(input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic [31:0] m,
                          input bit intrude, input string req);
        int nb;
        bit bad;
        int lat;
        logic [31:0] wm, em, old_v, new_v;
        case (sz)
            2'd0: begin nb = 1; wm = 32'hFF;       bad = 1'b0;   end
            2'd1: begin nb = 2; wm = 32'hFFFF;     bad = a[0];   end
            2'd2: begin nb = 4; wm = 32'hFFFFFFFF; bad = |a[1:0]; end
            default: begin nb = 0; wm = 32'h0;     bad = 1'b1;   end
        endcase
        old_v = '0;
        if (!bad) begin
            for (int b = 0; b < nb; b++) old_v |= 32'(ref_mem[int'(a) + b]) << (8 * b);
        end
        em    = m & wm;
        new_v = (old_v & ~em) | (d & wm & em);
        lat   = bad ? 1 : ((em == 0) ? RL + 1 : RL + 2);

        @(negedge clk);
        start_i = 1'b1; addr_i = a; size_i = sz; data_i = d; mask_i = m;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= lat + 1; i++) begin
            if (i > 1) @(negedge clk);
            if (intrude && lat >= 3 && i == 2) begin
                // R9: request while busy, aimed at another word
                start_i = 1'b1; addr_i = a ^ 8'h80; size_i = 2'd2;
                data_i = 32'hFFFF_FFFF; mask_i = 32'hFFFF_FFFF;
            end else begin
                start_i = 1'b0;
            end
            chk(done_o == (i == lat + 1), (bad ? "R8" : (em == 0 ? "R5" : "R6")),
                "done timing", 32'(done_o), 32'(i == lat + 1));
            chk(busy_o == (i <= lat), "R7", "busy", 32'(busy_o), 32'(i <= lat));
        end
        chk(err_o == bad, "R8", "err flag", 32'(err_o), 32'(bad));
        chk(old_o == old_v, req, "old value", old_o, old_v);
        if (!bad && em != 0) begin
            for (int b = 0; b < nb; b++) ref_mem[int'(a) + b] = new_v[8*b +: 8];
        end
    endtask

    task automatic read_word_check(input logic [AW-1:0] a, input string req);
        run_op(a, 2'd2, 32'h5A5A_5A5A, 32'h0, 1'b0, req);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'h00;
        rst_n = 1'b0; start_i = 1'b0; addr_i = '0; size_i = '0; data_i = '0; mask_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !busy_o && !err_o, "R1", "reset flags", {29'b0, done_o, busy_o, err_o}, 32'h0);
        chk(old_o == 32'h0, "R1", "reset old", old_o, 32'h0);
        read_word_check(8'h00, "R1");
        read_word_check(8'hFC, "R1");

        // R2/R6: full word write, then narrow reads of its lanes
        run_op(8'h10, 2'd2, 32'hA1B2_C3D4, 32'hFFFF_FFFF, 1'b0, "R6");
        run_op(8'h11, 2'd0, 32'h0, 32'h0, 1'b0, "R2");
        run_op(8'h12, 2'd1, 32'h0, 32'h0, 1'b0, "R2");
        run_op(8'h10, 2'd1, 32'h0, 32'h0, 1'b0, "R2");

        // R3/R4: bit merge in the top byte with garbage above the element
        run_op(8'h13, 2'd0, 32'hFFFF_FF0F, 32'hFFFF_FF3C, 1'b0, "R4");
        read_word_check(8'h10, "R3");
        run_op(8'h12, 2'd1, 32'h1234_00F0, 32'hABCD_0FF0, 1'b0, "R4");
        read_word_check(8'h10, "R6");

        // R5: zero mask and mask bits only above the element width
        run_op(8'h10, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b0, "R5");
        run_op(8'h11, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FF00, 1'b0, "R5");
        read_word_check(8'h10, "R5");

        // R8: faults
        run_op(8'h21, 2'd1, 32'hFFFF, 32'hFFFF, 1'b0, "R8");
        run_op(8'h22, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8");
        run_op(8'h20, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8");
        read_word_check(8'h20, "R8");

        // R9: a start during busy must be dropped
        run_op(8'h30, 2'd2, 32'h0BAD_F00D, 32'hFFFF_FFFF, 1'b1, "R9");
        read_word_check(8'hB0, "R9");
        run_op(8'h30, 2'd0, 32'h0, 32'h0, 1'b1, "R9");
        read_word_check(8'hB0, "R9");

        // Mixed traffic
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            logic [1:0]    sz;
            logic [31:0]   m;
            int pick;
            pick = $urandom_range(0, 9);
            sz = (pick < 3) ? 2'd0 : (pick < 6) ? 2'd1 : (pick < 9) ? 2'd2 : 2'd3;
            a  = AW'($urandom_range(0, NB - 1));
            if ($urandom_range(0, 3) != 0) begin
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            case ($urandom_range(0, 3))
                0: m = 32'h0;
                1: m = 32'hFFFF_FFFF;
                default: m = $urandom();
            endcase
            run_op(a, sz, $urandom(), m, 1'b0, "R3");
        end

        // Whole-memory sweep against the model
        for (int w = 0; w < NB / 4; w++) read_word_check(AW'(4 * w), "R6");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule